// File: doc/BRIEF.md
# DRAM Strobe-Sequence Decoder with Compressed Test Mode

This block sits on the device side of an asynchronous-strobe DRAM interface. It samples the active-low row strobe, column strobe and write enable on a system clock. On every falling edge of the row strobe it works out what kind of cycle is starting: an ordinary row access, a column-before-row refresh, a test-mode entry, or, once the row strobe rises without any column strobe, a row-only refresh. It holds that classification for as long as the row strobe stays low. Column-before-row cycles advance an internal refresh row counter.

The block also keeps a compressed-test-mode flag. A column-before-row cycle with write enable held low sets the flag. A plain column-before-row cycle or a row-only refresh clears it. While the flag is set, a column access treats the addressed location as a group of four neighbouring columns, each four bits wide, which is sixteen cells. A write stores one data bit into every cell of the group. A read drives an all-ones word when the sixteen cells agree and an all-zeros word when they do not. A small synthesizable cell array stands in for the storage, so that both modes can be checked against real contents.

Top module: `tmdec_top`

## Requirements
- R1: After synchronous reset, cyc_type is 0 (idle), test_mode is 0, rfsh_row is 0 and dq_oe is 0.
- R2: If ras_n is sampled falling while cas_n is high, the cycle is an access: cyc_type becomes 1 one clock later, addr is latched as the row, and cyc_type does not change while ras_n stays low.
- R3: If ras_n is sampled falling while cas_n is low and we_n is high, the cycle is a refresh: cyc_type becomes 2 and test_mode is cleared.
- R4: If ras_n is sampled falling while cas_n and we_n are both low, the cycle is a test entry: cyc_type becomes 3 and test_mode is set.
- R5: rfsh_row advances by one on every refresh or test-entry cycle and wraps from 2047 to 0. Access cycles leave it unchanged.
- R6: An access cycle whose row strobe rises without any column strobe fall is a row-only refresh. For one clock after the rise, cyc_type is 4 and test_mode is cleared; cyc_type then returns to 0.
- R7: Outside test mode, a cas_n fall during an access with we_n low writes dq_in to the cell at {row, column}. With we_n high, the stored word appears on dq_out with dq_oe high one clock after the fall. dq_oe stays high until the clock after ras_n is sampled high.
- R8: In test mode, a write copies dq_in[0] into all four bits of the four columns that share addr[3:2]. addr[1:0] and dq_in[3:1] are ignored, and other groups are untouched.
- R9: In test mode, a read drives dq_out to 4'b1111 when all sixteen cells of the group hold the same value and to 4'b0000 otherwise.
- R10: A test-entry cycle made while test mode is already set keeps test mode set and still advances rfsh_row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 4 | Multiplexed row/column address |
| dq_in | input | 4 | Write data |
| dq_out | output | 4 | Read data or test agreement word |
| dq_oe | output | 1 | Read data is being driven |
| cyc_type | output | 3 | Cycle class: 0 idle, 1 access, 2 refresh, 3 test entry, 4 row-only refresh |
| test_mode | output | 1 | Compressed test mode is active |
| rfsh_row | output | 11 | Internal refresh row counter |

## Verification
Two things can happen on the same row-strobe fall: a refresh step, which advances the row counter, and a mode change, which is test-mode entry or exit. The bench provokes this with plain and write-enable column-before-row cycles issued both outside and inside test mode, including a repeated entry while the mode is already set. In each case it checks the cycle class, the mode flag and the counter one clock after the fall. The mode change is then confirmed through its effect on later reads: agreement words versus stored data, and both a failing and a passing group.

// File: rtl/tmdec_pkg.sv
package tmdec_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE       = 3'd0,
        CYC_ACCESS     = 3'd1,
        CYC_REFRESH    = 3'd2,
        CYC_TEST_ENTRY = 3'd3,
        CYC_ROW_ONLY   = 3'd4
    } cyc_e;

    // Compressed test mode merges 2**GRP_COL_BITS columns into one group
    localparam int GRP_COL_BITS = 2;
    localparam int GRP_COLS     = 1 << GRP_COL_BITS;

    typedef struct packed {
        logic go;
        logic wr;
    } acc_req_t;

    // All cells agree when the vector is all ones or all zeros
    function automatic logic all_agree(input logic [63:0] cells, input int n);
        logic ones;
        logic zeros;
        ones  = 1'b1;
        zeros = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i < n) begin
                ones  = ones & cells[i];
                zeros = zeros & ~cells[i];
            end
        end
        return ones | zeros;
    endfunction

endpackage

// File: rtl/tmdec_strobe.sv
module tmdec_strobe
    import tmdec_pkg::*;
#(
    parameter int AW     = 4,
    parameter int RFSH_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [AW-1:0]     addr,
    output cyc_e              cyc,
    output logic              tm,
    output logic [RFSH_W-1:0] ctr,
    output logic [AW-1:0]     row,
    output acc_req_t          req
);

    logic ras_q, cas_q, col_seen_q;
    logic ras_fall, ras_rise;
    cyc_e cyc_q;

    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;

    always_comb begin
        req.go = (cyc_q == CYC_ACCESS) & cas_q & ~cas_n & ~ras_n & ~ras_q;
        req.wr = ~we_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q      <= 1'b1;
            cas_q      <= 1'b1;
            cyc_q      <= CYC_IDLE;
            tm         <= 1'b0;
            ctr        <= '0;
            row        <= '0;
            col_seen_q <= 1'b0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (ras_fall) begin
                if (!cas_n) begin
                    ctr <= ctr + 1'b1;
                    if (!we_n) begin
                        cyc_q <= CYC_TEST_ENTRY;
                        tm    <= 1'b1;
                    end else begin
                        cyc_q <= CYC_REFRESH;
                        tm    <= 1'b0;
                    end
                end else begin
                    cyc_q      <= CYC_ACCESS;
                    row        <= addr;
                    col_seen_q <= 1'b0;
                end
            end else if (ras_rise) begin
                if (cyc_q == CYC_ACCESS && !col_seen_q) begin
                    cyc_q <= CYC_ROW_ONLY;
                    tm    <= 1'b0;
                end else begin
                    cyc_q <= CYC_IDLE;
                end
            end else begin
                if (cyc_q == CYC_ROW_ONLY) cyc_q <= CYC_IDLE;
                if (req.go) col_seen_q <= 1'b1;
            end
        end
    end

    assign cyc = cyc_q;

    // R2: classification is held while the row strobe stays low
    p_hold_class_r2: assert property (@(posedge clk) disable iff (rst)
        (!ras_q && !ras_n) |=> (cyc_q == $past(cyc_q)));

    // R4: write-enable refresh sets test mode
    p_enter_tm_r4: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && !cas_n && !we_n) |=> tm);

    // R3: plain refresh clears test mode
    p_exit_tm_r3: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && !cas_n && we_n) |=> !tm);

    // R5: counter advances by one on every refresh-class fall
    p_ctr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && !cas_n) |=> (ctr == $past(ctr) + 1'b1));

    // R5: access cycles leave the counter alone
    p_ctr_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && cas_n) |=> $stable(ctr));

endmodule

// File: rtl/tmdec_cells.sv
module tmdec_cells
    import tmdec_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ras_n,
    input  acc_req_t        req,
    input  logic            tm,
    input  logic [AW-1:0]   row,
    input  logic [AW-1:0]   col,
    input  logic [DQ_W-1:0] din,
    output logic [DQ_W-1:0] dout,
    output logic            oe
);

    localparam int IDX_W  = 2 * AW;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int GRP_W  = GRP_COLS * DQ_W;

    logic [DQ_W-1:0]  mem [DEPTH];
    logic [GRP_W-1:0] grp;
    logic [63:0]      grp_ext;
    logic             agree;
    logic             rd_tm_q;
    logic [IDX_W-1:0] idx;

    assign idx = {row, col};

    always_comb begin
        for (int k = 0; k < GRP_COLS; k++) begin
            grp[k*DQ_W +: DQ_W] =
                mem[{row, col[AW-1:GRP_COL_BITS], GRP_COL_BITS'(k)}];
        end
        grp_ext = 64'(grp);
        agree   = all_agree(grp_ext, GRP_W);
    end

    always_ff @(posedge clk) begin
        if (req.go && req.wr) begin
            if (tm) begin
                for (int k = 0; k < GRP_COLS; k++) begin
                    mem[{row, col[AW-1:GRP_COL_BITS], GRP_COL_BITS'(k)}] <= {DQ_W{din[0]}};
                end
            end else begin
                mem[idx] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe      <= 1'b0;
            dout    <= '0;
            rd_tm_q <= 1'b0;
        end else begin
            if (ras_n) oe <= 1'b0;
            if (req.go) begin
                if (req.wr) begin
                    oe <= 1'b0;
                end else begin
                    oe      <= 1'b1;
                    rd_tm_q <= tm;
                    dout    <= tm ? {DQ_W{agree}} : mem[idx];
                end
            end
        end
    end

    // R7: data output released once the row strobe is high
    p_oe_release_r7: assert property (@(posedge clk) disable iff (rst)
        ras_n |=> !oe);

    // R9: a test-mode read drives a uniform agreement word
    p_tm_word_r9: assert property (@(posedge clk) disable iff (rst)
        (oe && rd_tm_q) |-> ($countones(dout) == 0 || $countones(dout) == DQ_W));

endmodule

// File: rtl/tmdec_top.sv
module tmdec_top
    import tmdec_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DQ_W   = 4,
    parameter int RFSH_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [AW-1:0]     addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [2:0]        cyc_type,
    output logic              test_mode,
    output logic [RFSH_W-1:0] rfsh_row
);

    cyc_e          cyc;
    logic [AW-1:0] row;
    acc_req_t      req;

    tmdec_strobe #(.AW(AW), .RFSH_W(RFSH_W)) u_strobe (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .cyc   (cyc),
        .tm    (test_mode),
        .ctr   (rfsh_row),
        .row   (row),
        .req   (req)
    );

    tmdec_cells #(.AW(AW), .DQ_W(DQ_W)) u_cells (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .req   (req),
        .tm    (test_mode),
        .row   (row),
        .col   (addr),
        .din   (dq_in),
        .dout  (dq_out),
        .oe    (dq_oe)
    );

    assign cyc_type = cyc;

endmodule

// File: tb/tmdec_top_bench.sv
module tmdec_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ras_n, cas_n, we_n;
    logic [3:0]  addr, dq_in;
    logic [3:0]  dq_out;
    logic        dq_oe;
    logic [2:0]  cyc_type;
    logic        test_mode;
    logic [10:0] rfsh_row;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [10:0] exp_ctr = '0;

    always #2.5 clk = ~clk;

    tmdec_top u_tmdec_top (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cyc_type(cyc_type), .test_mode(test_mode), .rfsh_row(rfsh_row)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] r, input logic [3:0] c, input logic [3:0] d);
        ras_n = 1'b0; addr = r; step();
        chk(cyc_type == 3'd1, "R2 access class on write", cyc_type, 1);
        addr = c; we_n = 1'b0; dq_in = d; cas_n = 1'b0; step();
        cas_n = 1'b1; we_n = 1'b1; step();
        chk(cyc_type == 3'd1, "R2 class held", cyc_type, 1);
        ras_n = 1'b1; step();
        step();
    endtask

    task automatic do_read(input logic [3:0] r, input logic [3:0] c, output logic [3:0] d);
        ras_n = 1'b0; addr = r; step();
        addr = c; we_n = 1'b1; cas_n = 1'b0; step();
        chk(dq_oe == 1'b1, "R7 oe after column fall", dq_oe, 1);
        d = dq_out;
        cas_n = 1'b1; step();
        chk(dq_oe == 1'b1 && dq_out == d, "R7 data held after column rise", dq_out, d);
        ras_n = 1'b1; step();
        chk(dq_oe == 1'b0, "R7 oe released after row rise", dq_oe, 0);
        chk(cyc_type == 3'd0, "R2 idle after row rise", cyc_type, 0);
        step();
    endtask

    task automatic do_cbr(input logic we, input logic exp_tm, input string tag);
        cas_n = 1'b0; step();
        we_n = we; ras_n = 1'b0; step();
        exp_ctr = exp_ctr + 1'b1;
        chk(cyc_type == (we ? 3'd2 : 3'd3), {tag, " class"}, cyc_type, we ? 2 : 3);
        chk(test_mode == exp_tm, {tag, " mode flag"}, test_mode, exp_tm);
        chk(rfsh_row == exp_ctr, "R5 counter step", rfsh_row, exp_ctr);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step();
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0; dq_in = '0;
        repeat (3) step();
        rst = 1'b0; step();
        chk(cyc_type == 3'd0, "R1 reset class", cyc_type, 0);
        chk(test_mode == 1'b0, "R1 reset mode", test_mode, 0);
        chk(rfsh_row == 11'd0, "R1 reset counter", rfsh_row, 0);
        chk(dq_oe == 1'b0, "R1 reset oe", dq_oe, 0);
    endtask

    task automatic t_normal();
        logic [3:0] d;
        do_write(4'd2, 4'd4, 4'h5);
        do_write(4'd2, 4'd5, 4'hA);
        do_write(4'd2, 4'd6, 4'hF);
        do_write(4'd2, 4'd7, 4'h0);
        do_write(4'd2, 4'd8, 4'h9);
        do_write(4'd3, 4'd5, 4'h6);
        do_read(4'd2, 4'd5, d);
        chk(d == 4'hA, "R7 normal readback", d, 4'hA);
        do_read(4'd3, 4'd5, d);
        chk(d == 4'h6, "R7 row separation", d, 4'h6);
        chk(rfsh_row == exp_ctr, "R5 access leaves counter", rfsh_row, exp_ctr);
    endtask

    task automatic t_test_mode();
        logic [3:0] d;
        do_cbr(1'b0, 1'b1, "R4 test entry");
        do_read(4'd2, 4'd4, d);
        chk(d == 4'h0, "R9 mismatching group flags fail", d, 0);
        do_write(4'd2, 4'd6, 4'b0001);
        do_read(4'd2, 4'd5, d);
        chk(d == 4'hF, "R9 ones group passes R8", d, 4'hF);
        do_write(4'd2, 4'd7, 4'b1110);
        do_read(4'd2, 4'd4, d);
        chk(d == 4'hF, "R9 zeros group passes R8", d, 4'hF);
        do_cbr(1'b0, 1'b1, "R10 repeat entry");
        // row-only refresh
        ras_n = 1'b0; addr = 4'd1; step();
        chk(cyc_type == 3'd1, "R6 starts as access", cyc_type, 1);
        step();
        ras_n = 1'b1; step();
        chk(cyc_type == 3'd4, "R6 row-only class", cyc_type, 4);
        chk(test_mode == 1'b0, "R6 row-only exits test mode", test_mode, 0);
        chk(rfsh_row == exp_ctr, "R5 row-only leaves counter", rfsh_row, exp_ctr);
        step();
        chk(cyc_type == 3'd0, "R6 back to idle", cyc_type, 0);
        for (int c = 4; c < 8; c++) begin
            do_read(4'd2, 4'(c), d);
            chk(d == 4'h0, "R8 group cells all zero", d, 0);
        end
        do_read(4'd2, 4'd8, d);
        chk(d == 4'h9, "R8 neighbour group untouched", d, 4'h9);
        do_read(4'd3, 4'd5, d);
        chk(d == 4'h6, "R8 other row untouched", d, 4'h6);
        do_cbr(1'b0, 1'b1, "R4 re-entry");
        do_cbr(1'b1, 1'b0, "R3 plain refresh exit");
        do_read(4'd2, 4'd8, d);
        chk(d == 4'h9, "R3 normal data after exit", d, 4'h9);
    endtask

    task automatic t_wrap();
        while (exp_ctr != 11'd2047) begin
            cas_n = 1'b0; step();
            ras_n = 1'b0; step();
            exp_ctr = exp_ctr + 1'b1;
            ras_n = 1'b1; cas_n = 1'b1; step();
        end
        chk(rfsh_row == 11'd2047, "R5 counter at top", rfsh_row, 2047);
        do_cbr(1'b1, 1'b0, "R3 refresh at wrap");
        chk(rfsh_row == 11'd0, "R5 counter wraps to zero", rfsh_row, 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_test_mode();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule